// File: doc/BRIEF.md
# Single-Channel Device-to-Memory DMA Engine

This block moves a block of bytes from a device into system memory without the processor copying each byte. Software sets the first memory address and the number of bytes, picks one of two bus policies, and sets the go bit. The engine then asks the processor for the shared bus with a request/grant handshake. While it is granted, it drives the memory address, write data and write strobe itself. Each byte it writes is taken from the device through a valid/take handshake.

There are two bus policies. In burst policy the engine holds the bus from the first grant until the last byte of the block. A device gap during the block stalls the bus but does not release it. In cycle-steal policy the engine writes one byte and then hands the bus back. It asks again only when the device offers its next byte. When the remaining count reaches zero and the bus has been returned, the engine raises a level interrupt. That interrupt stays high until software clears it.

The sequencer has five states:
- IDLE: waiting for go.
- REQUEST: asking for the bus while a byte is offered.
- TRANSFER: bus owned; one write per offered byte.
- RELEASE: request dropped; waiting for the grant to fall.
- DONE: one cycle that sets the interrupt.

It has eight transitions:
- go with a non-zero count: IDLE to REQUEST.
- go with a zero count: IDLE to DONE.
- byte offered and grant seen: REQUEST to TRANSFER.
- last byte written, or any byte written in cycle-steal policy: TRANSFER to RELEASE.
- grant low with bytes left: RELEASE to REQUEST.
- grant low with no bytes left: RELEASE to DONE.
- always: DONE to IDLE.
- otherwise the state holds.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After reset, bus_req, mem_we, dev_take, done_irq and busy are all low.
- R2: bus_req rises only while dev_valid is high. mem_we is never high unless bus_grant is high.
- R3: Write n of a block goes to the start address plus n, modulo 2^ADDR_W. It carries the device's byte n. dev_take is high in exactly the cycles in which mem_we is high.
- R4: A block with count N makes exactly N memory writes. The remaining count never steps below zero.
- R5: In burst policy (control bit 1 = 0), bus_req rises once per block and stays high from the first grant until the last write.
- R6: In cycle-steal policy (control bit 1 = 1), each bus ownership makes at most one write. bus_req is low in the cycle after every write, so a block of N bytes raises bus_req N times.
- R7: bus_req is low in the cycle after the last write. The engine stays in release, without asking again, while bus_grant is still high.
- R8: done_irq goes high once a block has completed. It stays high until a control write with bit 2 set clears it.
- R9: A go with a remaining count of zero raises done_irq within two cycles and never raises bus_req.
- R10: While busy is high, writes to the start address (cfg_sel 0) and the count (cfg_sel 1) are ignored. A go (cfg_sel 2, bit 0) is also ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 start address, 1 count, 2 control |
| cfg_wdata | input | ADDR_W | Write data; the count uses the low CNT_W bits. Control bits: 0 go, 1 cycle-steal policy, 2 clear interrupt |
| dev_valid | input | 1 | Device offers a byte; must hold until dev_take |
| dev_data | input | DATA_W | Offered byte |
| dev_take | output | 1 | Byte consumed at this clock edge |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Bus handed to the engine |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| done_irq | output | 1 | Completion interrupt, level |
| busy | output | 1 | Engine is not idle |

## Verification
The bench applies random blocks and directed blocks with random device gaps and grant latencies, and goes after the following corner cases.

- **Device gap inside a burst.** A design that dropped the request during the gap would raise bus_req more than once per block.
- **Cycle-steal policy.** An engine that kept the bus would show two writes in one ownership, or a high request right after a write.
- **Zero count.** A design that started a transfer would raise bus_req or write memory.
- **Address wrap at the top of the space.** A wrong increment would write to the wrong place.
- **Configuration written in the middle of a block.** A design that accepted it would write to the new address or start a second block.
- **Interrupt that must persist until cleared.** A design that pulsed it would read low a few cycles after completion.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_TRANSFER,
        ST_RELEASE,
        ST_DONE
    } dma_state_e;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_STEAL_BIT = 1;
    localparam int CTRL_CLR_BIT   = 2;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              busy,
    output logic [ADDR_W-1:0] shadow_base,
    output logic [CNT_W-1:0]  shadow_cnt,
    output logic              mode_steal,
    output logic              go,
    output logic              irq_clr
);
    import dma_pkg::*;

    logic wr_base, wr_cnt, wr_ctrl;

    always_comb begin
        wr_base = cfg_wr && (cfg_sel == SEL_BASE)  && !busy;
        wr_cnt  = cfg_wr && (cfg_sel == SEL_COUNT) && !busy;
        wr_ctrl = cfg_wr && (cfg_sel == SEL_CTRL);
        go      = wr_ctrl && !busy && cfg_wdata[CTRL_GO_BIT];
        irq_clr = wr_ctrl && cfg_wdata[CTRL_CLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_base <= '0;
            shadow_cnt  <= '0;
            mode_steal  <= 1'b0;
        end else begin
            if (wr_base) shadow_base <= cfg_wdata;
            if (wr_cnt)  shadow_cnt  <= cfg_wdata[CNT_W-1:0];
            if (wr_ctrl && !busy) mode_steal <= cfg_wdata[CTRL_STEAL_BIT];
        end
    end

    // R10: programmed values cannot move while a block is running
    a_r10_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(shadow_base) && $stable(shadow_cnt) && $stable(mode_steal)));

endmodule

// File: rtl/dma_addr_count.sv
module dma_addr_count #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_one,
    output logic              none_left
);
    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_DEC  = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_cnt;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_INC;
            remain   <= remain - CNT_DEC;
        end
    end

    always_comb begin
        last_one  = (remain == CNT_DEC);
        none_left = (remain == '0);
    end

    // R4: a write is never issued against an exhausted count
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !none_left);

    // R3: each write advances the address by exactly one
    a_r3_addr_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cur_addr == $past(cur_addr) + ADDR_INC));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic zero_len,
    input  logic mode_steal,
    input  logic last_one,
    input  logic none_left,
    input  logic dev_valid,
    input  logic bus_grant,
    output logic bus_req,
    output logic fire,
    output logic load,
    output logic done_pulse,
    output logic busy
);
    import dma_pkg::*;

    dma_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        bus_req    = 1'b0;
        fire       = 1'b0;
        load       = 1'b0;
        done_pulse = 1'b0;
        busy       = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (go) begin
                    load     = 1'b1;
                    state_nx = zero_len ? ST_DONE : ST_REQUEST;
                end
            end
            ST_REQUEST: begin
                bus_req = dev_valid;
                if (dev_valid && bus_grant) state_nx = ST_TRANSFER;
            end
            ST_TRANSFER: begin
                bus_req = 1'b1;
                fire    = dev_valid && bus_grant;
                if (fire && (last_one || mode_steal)) state_nx = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!bus_grant) state_nx = none_left ? ST_DONE : ST_REQUEST;
            end
            ST_DONE: begin
                done_pulse = 1'b1;
                state_nx   = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R2: memory is only written while the bus is granted
    a_r2_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> bus_grant);

    // R5: burst policy keeps ownership until the final byte
    a_r5_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRANSFER && !mode_steal && !(fire && last_one))
        |=> (state == ST_TRANSFER && bus_req));

    // R6: cycle-steal policy gives the bus back after one byte
    a_r6_steal_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_steal) |=> !bus_req);

    // R7: request drops right after the final byte
    a_r7_last_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last_one) |=> !bus_req);

    // R7: no new request while the grant is still up
    a_r7_release_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE && bus_grant) |=> (state == ST_RELEASE && !bus_req));

    // R9: zero count completes without touching the bus
    a_r9_zero_skips_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && go && zero_len) |=> (state == ST_DONE && !bus_req));

endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_take,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              done_irq,
    output logic              busy
);
    logic [ADDR_W-1:0] shadow_base;
    logic [CNT_W-1:0]  shadow_cnt;
    logic              mode_steal, go, irq_clr;
    logic              fire, load, done_pulse, last_one, none_left;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) cfg_u (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .shadow_base(shadow_base),
        .shadow_cnt(shadow_cnt), .mode_steal(mode_steal), .go(go),
        .irq_clr(irq_clr)
    );

    dma_addr_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) cnt_u (
        .clk(clk), .rst_n(rst_n), .load(load), .step(fire),
        .load_addr(shadow_base), .load_cnt(shadow_cnt),
        .cur_addr(mem_addr), .last_one(last_one), .none_left(none_left)
    );

    dma_seq_fsm seq_u (
        .clk(clk), .rst_n(rst_n), .go(go), .zero_len(shadow_cnt == '0),
        .mode_steal(mode_steal), .last_one(last_one), .none_left(none_left),
        .dev_valid(dev_valid), .bus_grant(bus_grant), .bus_req(bus_req),
        .fire(fire), .load(load), .done_pulse(done_pulse), .busy(busy)
    );

    always_comb begin
        mem_we    = fire;
        dev_take  = fire;
        mem_wdata = dev_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          done_irq <= 1'b0;
        else if (done_pulse) done_irq <= 1'b1;
        else if (irq_clr)    done_irq <= 1'b0;
    end

    // R8: the interrupt persists until a control write with the clear bit
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !(cfg_wr && cfg_sel == dma_pkg::SEL_CTRL
                       && cfg_wdata[dma_pkg::CTRL_CLR_BIT])) |=> done_irq);

    // R1: nothing is driven toward the bus while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !mem_we));

endmodule

// File: tb/dma_steal_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_steal_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dev_valid = 1'b0;
    logic [DW-1:0] dev_data = '0;
    logic          bus_grant = 1'b0;
    logic          dev_take, bus_req, mem_we, done_irq, busy;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    always #2 clk = ~clk;

    dma_steal_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_valid(dev_valid), .dev_data(dev_data),
        .dev_take(dev_take), .bus_req(bus_req), .bus_grant(bus_grant),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .done_irq(done_irq), .busy(busy)
    );

    int checks = 0;
    int fails = 0;
    bit dev_on = 0;
    bit pend = 0;
    int dev_idx = 0, dev_n = 0, dev_gap = 0, dev_maxgap = 0, seed_b = 0;
    int lat_cfg = 0, lat_cnt = 0;
    int wr_seen = 0, req_rises = 0, win_writes = 0;
    bit prev_req = 0, after_last = 0, steal_after = 0, steal_cur = 0;
    logic [AW-1:0] exp_base = '0;

    function automatic logic [DW-1:0] exp_byte(int s, int i);
        return DW'((s * 29 + i * 53 + 7) ^ (i >> 2));
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: got 0 expected 1 (run completion)");
        summary();
        $finish;
    end

    // device, arbiter and bus monitor, all acting at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req && !bus_grant) begin
                if (lat_cnt >= lat_cfg) begin bus_grant = 1'b1; lat_cnt = 0; end
                else lat_cnt++;
            end else if (!bus_req && bus_grant) begin
                bus_grant = 1'b0;
            end
            if (pend) begin
                pend = 0;
                dev_idx++;
                if (dev_idx < dev_n) begin
                    dev_gap   = (dev_maxgap > 0) ? $urandom_range(dev_maxgap, 0) : 0;
                    dev_valid = (dev_gap == 0);
                    dev_data  = exp_byte(seed_b, dev_idx);
                end else begin
                    dev_valid = 1'b0;
                end
            end else if (dev_on && !dev_valid && dev_idx < dev_n) begin
                if (dev_gap > 0) dev_gap--;
                if (dev_gap == 0) begin
                    dev_valid = 1'b1;
                    dev_data  = exp_byte(seed_b, dev_idx);
                end
            end
            #1;
            if (after_last) begin
                chk(!bus_req, "R7", "bus_req after last write", bus_req, 0);
                after_last = 0;
            end
            if (steal_after) begin
                chk(!bus_req, "R6", "bus_req after stolen cycle", bus_req, 0);
                steal_after = 0;
            end
            if (bus_req && !prev_req) begin
                req_rises++;
                win_writes = 0;
                chk(dev_valid, "R2", "dev_valid at request rise", dev_valid, 1);
            end
            if (mem_we) begin
                chk(bus_grant, "R2", "grant during write", bus_grant, 1);
                chk(mem_addr == AW'(exp_base + AW'(wr_seen)), "R3", "write address",
                    mem_addr, AW'(exp_base + AW'(wr_seen)));
                chk(mem_wdata == exp_byte(seed_b, wr_seen), "R3", "write data",
                    mem_wdata, exp_byte(seed_b, wr_seen));
                chk(dev_take, "R3", "dev_take with write", dev_take, 1);
                wr_seen++;
                win_writes++;
                if (steal_cur) begin
                    chk(win_writes == 1, "R6", "writes per ownership", win_writes, 1);
                    steal_after = 1;
                end
                pend = 1;
                if (wr_seen == dev_n) after_last = 1;
            end else if (dev_take) begin
                chk(0, "R3", "dev_take without write", dev_take, 0);
            end
            prev_req = bus_req;
        end
    end

    task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_block(logic [AW-1:0] base, int n, bit steal, int lat,
                             int maxgap, bit midcfg);
        int waited;
        seed_b     = $urandom_range(1000, 0);
        dev_n      = n;
        dev_idx    = 0;
        dev_maxgap = maxgap;
        dev_gap    = (maxgap > 0) ? $urandom_range(maxgap, 0) : 0;
        dev_valid  = 1'b0;
        dev_data   = exp_byte(seed_b, 0);
        wr_seen    = 0;
        req_rises  = 0;
        exp_base   = base;
        steal_cur  = steal;
        lat_cfg    = lat;
        lat_cnt    = 0;
        cfg_write(2'd1, AW'(n));
        cfg_write(2'd0, base);
        dev_on = 1;
        cfg_write(2'd2, AW'(5 | (steal ? 2 : 0)));
        if (midcfg) begin
            cfg_write(2'd0, 16'hDEAD);
            cfg_write(2'd1, 16'd3);
            cfg_write(2'd2, 16'd1);
        end
        waited = 0;
        while (!done_irq && waited < 5000) begin
            @(negedge clk); #1;
            waited++;
        end
        chk(done_irq, "R8", "done_irq after block", done_irq, 1);
        chk(wr_seen == n, "R4", "write count", wr_seen, n);
        if (n == 0) begin
            chk(waited <= 2, "R9", "cycles to done on zero count", waited, 2);
            chk(req_rises == 0, "R9", "requests on zero count", req_rises, 0);
        end else if (steal) begin
            chk(req_rises == n, "R6", "request rises in steal policy", req_rises, n);
        end else begin
            chk(req_rises == 1, "R5", "request rises in burst policy", req_rises, 1);
        end
        dev_on = 0;
        repeat (3) begin @(negedge clk); end
        #1;
        chk(!busy, "R10", "idle after block", busy, 0);
        chk(wr_seen == n, "R10", "no extra writes after block", wr_seen, n);
        chk(done_irq, "R8", "done_irq held", done_irq, 1);
        cfg_write(2'd2, 16'd4);
        #1;
        chk(!done_irq, "R8", "done_irq cleared", done_irq, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_req && !mem_we && !dev_take, "R1", "bus outputs in reset",
            {bus_req, mem_we, dev_take}, 0);
        chk(!done_irq && !busy, "R1", "irq/busy in reset", {done_irq, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!bus_req && !busy && !done_irq, "R1", "after reset release",
            {bus_req, busy, done_irq}, 0);

        run_block(16'h0100, 1, 1'b0, 0, 0, 1'b0);     // burst single byte
        run_block(16'h0200, 1, 1'b1, 2, 0, 1'b0);     // steal single byte
        run_block(16'h0300, 0, 1'b0, 0, 0, 1'b0);     // R9 zero count
        run_block(16'h0300, 0, 1'b1, 0, 0, 1'b0);     // R9 zero count, steal
        run_block(16'hFFF0, 300, 1'b0, 0, 0, 1'b0);   // R3 address wrap, long burst
        run_block(16'h1000, 24, 1'b0, 3, 3, 1'b0);    // R5 gaps inside burst
        run_block(16'h2000, 24, 1'b1, 2, 3, 1'b1);    // R10 config while busy
        run_block(16'h3000, 20, 1'b0, 1, 2, 1'b1);    // R10 config while busy, burst
        for (int k = 0; k < 12; k++) begin
            run_block(AW'($urandom_range(65535, 0)), $urandom_range(40, 1),
                      1'($urandom_range(1, 0)), $urandom_range(3, 0),
                      $urandom_range(3, 0), 1'b0);
        end
        summary();
        $finish;
    end

endmodule